// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Flags

This block watches twelve asynchronous interrupt pins. Each pin passes through a synchronizer, and a per-line polarity bit selects whether a rising or a falling transition of the synchronized signal counts as an event. An event sets a sticky flag for that line. The flag stays set until software writes a 0 to it or the block is reset. Software can also write a 1 to a flag to force an interrupt.

The flags are visible through a byte-wide register port with two addresses. Address 0 holds lines 0 to 7 in bits 7:0. Address 1 holds lines 8 to 11 in bits 3:0, and its bits 7:4 are reserved. Each flag is ANDed with a per-line enable to form a pending vector, and a single request line is the OR of that vector. The polarity and enable vectors come from elsewhere in the register file as plain inputs. The vectoring logic that consumes the request is outside this block.

Top module: `ext_irq_flags`

## Requirements
- R1: A line whose polarity bit is 1 sets its flag when its synchronized pin goes from 0 to 1. A pin change driven between clock edges is visible in the flag, and therefore in `reg_rdata_o`, after the third following rising clock edge and not after the second.
- R2: A line whose polarity bit is 0 sets its flag when its synchronized pin goes from 1 to 0.
- R3: A transition in the direction opposite to the line's polarity does not set the flag. A pin held at a constant level does not set the flag. Changing a polarity bit while the pin is steady does not set the flag.
- R4: Once set, a flag stays set through later pin transitions of either direction and through the pin returning to idle. It is cleared only by a software write of 0 or by reset.
- R5: A write (`reg_wr_i`=1) loads the selected register's implemented bits from `reg_wdata_i`. A 0 clears a flag and a 1 sets it. Address 0 bit n is line n (n=0..7), and address 1 bit n is line 8+n (n=0..3).
- R6: If a pin event and a software write of 0 reach the same flag on the same clock edge, the flag ends set.
- R7: Bits 7:4 at address 1 always read 0, and writing 1s to them has no effect.
- R8: Reset clears all flags. Pin levels present when reset is released do not produce flags, because event detection stays masked until the synchronizer pipeline holds post-reset samples.
- R9: `pend_o[n]` is flag n AND `irq_en_i[n]`, and `irq_o` is 1 exactly when any `pend_o` bit is 1. Dropping an enable masks the request but does not clear the flag.
- R10: `reg_rdata_o` shows the register chosen by `reg_sel_i` combinationally. A write takes effect at the clock edge on which `reg_wr_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 12 | Asynchronous interrupt pins, one per line |
| edge_pol_i | input | 12 | Per-line polarity: 1 = rising edge, 0 = falling edge |
| irq_en_i | input | 12 | Per-line interrupt enable |
| reg_sel_i | input | 1 | Register address: 0 = lines 0..7, 1 = lines 8..11 |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| pend_o | output | 12 | Flag AND enable, per line |
| irq_o | output | 1 | OR of all pending bits |

## Verification
The main stimulus is a set of single-line pin transitions. It covers rising and falling pins on rising-type and falling-type lines, plus pins that do not move, spread across both registers. Matched pairs show that polarity is honoured, and mismatched pairs show that only the selected direction counts. Steady pins separate a real event from mere level sensitivity. Directed sequences then cover:
- holding all pins active through reset release;
- flipping a polarity bit under a steady pin;
- returning a set flag's pin to idle and toggling it back;
- timing a write of 0 to land on the same clock edge as an event;
- writing 1s into the reserved bits;
- toggling enables while a flag is set.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Polarity encoding used on edge_pol_i
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    function automatic int regs_for(input int lines, input int width);
        return (lines + width - 1) / width;
    endfunction

    function automatic int sel_bits(input int regs);
        return (regs > 1) ? $clog2(regs) : 1;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int N      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o,
    output logic         prime_o
);
    localparam int FILL  = STAGES + 1;
    localparam int CNT_W = $clog2(FILL + 1);

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [N-1:0]             prev;
        logic [CNT_W-1:0]         cnt;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
        if (st_q.cnt != CNT_W'(FILL)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o   = st_q.chain[STAGES-1];
    assign prev_o  = st_q.prev;
    assign prime_o = (st_q.cnt == CNT_W'(FILL));

    // R8
    prime_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prime_o |=> prime_o);

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import ext_irq_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] pol_i,
    input  logic         prime_i,
    output logic [N-1:0] edge_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise_d, fall_d;
        always_comb begin
            rise_d = cur_i[g] & ~prev_i[g];
            fall_d = ~cur_i[g] & prev_i[g];
            if (!prime_i) begin
                edge_o[g] = 1'b0;
            end else if (edge_pol_e'(pol_i[g]) == POL_RISE) begin
                edge_o[g] = rise_d;
            end else begin
                edge_o[g] = fall_d;
            end
        end
    end

    // R3
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o & ~(cur_i ^ prev_i)) == '0);

    // R8
    edge_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prime_i |-> (edge_o == '0));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import ext_irq_pkg::*;
#(
    parameter int N      = 12,
    parameter int DATA_W = 8,
    localparam int NREGS = regs_for(N, DATA_W),
    localparam int SEL_W = sel_bits(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      edge_i,
    input  logic              wr_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N-1:0]      flags_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W    = NREGS * DATA_W;
    localparam int TOP_USED = N - (NREGS - 1) * DATA_W;

    typedef struct packed {
        logic [N-1:0] flag;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [N-1:0]                   hit_d;
    logic [N-1:0]                   wbit_d;
    logic [PAD_W-1:0]               padded_d;
    logic [NREGS-1:0][DATA_W-1:0]   view_d;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit_d[i]  = wr_i && ((i / DATA_W) == int'(sel_i));
            wbit_d[i] = wdata_i[i % DATA_W];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (hit_d[i]) begin
                st_d.flag[i] = wbit_d[i];
            end
            if (edge_i[i]) begin
                st_d.flag[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o  = st_q.flag;
    assign padded_d = PAD_W'(st_q.flag);

    for (genvar r = 0; r < NREGS; r++) begin : g_view
        assign view_d[r] = padded_d[r*DATA_W +: DATA_W];
    end

    always_comb begin
        if (int'(sel_i) < NREGS) begin
            rdata_o = view_d[sel_i];
        end else begin
            rdata_o = '0;
        end
    end

    // R4
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(flags_o & ~hit_d)) == $past(flags_o & ~hit_d)));

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_i) |=> ((flags_o & $past(edge_i)) == $past(edge_i)));

    // R3
    no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(edge_i | (hit_d & wbit_d))) == '0));

    if (TOP_USED < DATA_W) begin : g_rsvd
        // R7
        reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel_i) == NREGS - 1) |-> ((rdata_o >> TOP_USED) == '0));
    end

endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES   = 12,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NREGS      = regs_for(NUM_LINES, DATA_W),
    localparam int SEL_W      = sel_bits(NREGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_pin_i,
    input  logic [NUM_LINES-1:0] edge_pol_i,
    input  logic [NUM_LINES-1:0] irq_en_i,
    input  logic [SEL_W-1:0]     reg_sel_i,
    input  logic                 reg_wr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic [NUM_LINES-1:0] pend_o,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] cur_w, prev_w, edge_w, flags_w;
    logic                 prime_w;

    irq_pin_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (irq_pin_i),
        .cur_o   (cur_w),
        .prev_o  (prev_w),
        .prime_o (prime_w)
    );

    irq_edge_detect #(.N(NUM_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_i   (cur_w),
        .prev_i  (prev_w),
        .pol_i   (edge_pol_i),
        .prime_i (prime_w),
        .edge_o  (edge_w)
    );

    irq_flag_bank #(.N(NUM_LINES), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (edge_w),
        .wr_i    (reg_wr_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .flags_o (flags_w),
        .rdata_o (reg_rdata_o)
    );

    assign pend_o = flags_w & irq_en_i;
    assign irq_o  = |pend_o;

    // R9
    pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~irq_en_i) == '0);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i == '0) |-> !irq_o);

endmodule

// File: tb/ext_irq_flags_bench.sv
module ext_irq_flags_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pins = '0;
    logic [11:0] pol = '1;
    logic [11:0] en = '1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [11:0] pend;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ext_irq_flags u_ext_irq_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pin_i   (pins),
        .edge_pol_i  (pol),
        .irq_en_i    (en),
        .reg_sel_i   (sel),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pend_o      (pend),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [3:0] line;
        logic       pol;
        logic       lvl0;
        logic       lvl1;
        logic       en;
        logic       exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{4'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd8,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'd9,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'd11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic s, output logic [7:0] d);
        @(negedge clk);
        sel = s;
        #1 d = rdata;
    endtask

    task automatic clear_all();
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_b;
        // R8: pins active and rising polarity through reset release
        pins = 12'hFFF; pol = 12'hFFF; en = 12'hFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        rd_reg(1'b0, d); chk("R8 reset low reg", d, 8'h00);
        rd_reg(1'b1, d); chk("R8 reset high reg", d, 8'h00);
        chk("R8 reset pend", pend, 12'h000);
        chk("R8 reset irq", irq, 1'b0);
        pins = '0;
        repeat (5) @(negedge clk);
        clear_all();

        // Vector walk: R1 R2 R3 R9
        for (int v = 0; v < NV; v++) begin
            pol = 12'hFFF; pins = '0; en = 12'hFFF;
            pol[VECS[v].line] = VECS[v].pol;
            en[VECS[v].line]  = VECS[v].en;
            pins[VECS[v].line] = VECS[v].lvl0;
            repeat (5) @(negedge clk);
            clear_all();
            @(negedge clk);
            pins[VECS[v].line] = VECS[v].lvl1;
            repeat (4) @(negedge clk);
            rd_reg(VECS[v].line >= 4'd8, d);
            exp_b = 8'(VECS[v].exp) << (VECS[v].line % 8);
            chk(VECS[v].exp ? (VECS[v].pol ? "R1 vec flag" : "R2 vec flag") : "R3 vec flag", d, exp_b);
            chk("R9 vec pend", pend, 12'(VECS[v].exp & VECS[v].en) << VECS[v].line);
            chk("R9 vec irq", irq, VECS[v].exp & VECS[v].en);
        end

        // R1 latency: set after third edge, not second
        pins = '0; pol = 12'hFFF; en = 12'hFFF;
        repeat (4) @(negedge clk);
        clear_all();
        @(negedge clk);
        sel = 1'b0;
        pins[2] = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk("R1 not yet after 2 edges", rdata, 8'h00);
        @(negedge clk);
        #1 chk("R1 set after 3 edges", rdata, 8'h04);

        // R4 sticky through idle return and re-toggle
        pins[2] = 1'b0;
        repeat (5) @(negedge clk);
        pins[2] = 1'b1;
        repeat (5) @(negedge clk);
        pins[2] = 1'b0;
        repeat (5) @(negedge clk);
        rd_reg(1'b0, d); chk("R4 sticky", d, 8'h04);
        // R5 software clear
        wr_reg(1'b0, 8'h00);
        #1 chk("R5 clear by write 0", rdata, 8'h00);

        // R3 polarity flip under steady pin
        pol[4] = 1'b0; pins[4] = 1'b1;
        repeat (5) @(negedge clk);
        clear_all();
        pol[4] = 1'b1;
        repeat (5) @(negedge clk);
        rd_reg(1'b0, d); chk("R3 polarity flip no flag", d, 8'h00);
        pins[4] = 1'b0; pol[4] = 1'b1;
        repeat (5) @(negedge clk);

        // R5 software set and R9 request
        en = '0;
        wr_reg(1'b0, 8'hA5);
        #1 chk("R5 force set low", rdata, 8'hA5);
        chk("R9 enables off pend", pend, 12'h000);
        chk("R9 enables off irq", irq, 1'b0);
        en = 12'h001;
        #1 chk("R9 single enable pend", pend, 12'h001);
        chk("R9 single enable irq", irq, 1'b1);
        en = '0;
        rd_reg(1'b0, d); chk("R9 flag kept when disabled", d, 8'hA5);
        en = 12'hFFF;

        // R7 reserved bits
        wr_reg(1'b1, 8'hFF);
        #1 chk("R7 reserved read zero", rdata, 8'h0F);
        chk("R5 high reg lines", pend, 12'hFA5);
        clear_all();
        #1 chk("R5 high reg cleared", rdata, 8'h00);

        // R6 edge and write 0 on the same edge
        pins = '0; pol = 12'hFFF;
        repeat (4) @(negedge clk);
        clear_all();
        @(negedge clk);
        pins[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; wdata = 8'h00;
        @(negedge clk);
        wr = 1'b0;
        #1 chk("R6 edge beats clear", rdata, 8'h02);

        // R10 combinational read select
        wr_reg(1'b1, 8'h08);
        @(negedge clk);
        sel = 1'b0; #1 chk("R10 read low", rdata, 8'h02);
        sel = 1'b1; #1 chk("R10 read high", rdata, 8'h08);

        finish_run();
    end

endmodule